// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block guesses the value that a pointer-loading instruction will return when that load misses in the L2 cache while the core is running ahead. Many loads that fetch pointers show a fixed gap between the address they read and the value they read. Linked nodes laid out at a fixed spacing produce such a gap, and so does a node that sits right next to the string it points to. The block learns that gap per load instruction and uses it to rebuild the value from the address alone.

Training happens when a load retires in normal mode. The block takes the load's program counter, effective address and loaded data, and forms the delta as address minus data. Deltas whose magnitude exceeds a configured bound are treated as "not a pointer" and are dropped. Accepted deltas live in a small set-associative table keyed by the load's program counter, with a saturating confidence counter per entry.

A runahead-mode L2 miss presents its program counter and effective address on the lookup port. One cycle later the block returns a valid flag and the address minus the stored delta. The valid flag is raised only when the entry is confident. The table is never rolled back, because a wrong guess in runahead mode costs nothing architecturally.

Top module: `avd_predictor`

## Requirements
- R1: After reset the table is empty: predValid is 0, and no lookup produces a prediction until training has happened.
- R2: The delta of a training load is trainAddr minus trainData, taken modulo 2^ADDR_W and read as signed. A prediction returns lookupAddr minus the stored delta, modulo 2^ADDR_W.
- R3: A training load is accepted only when its delta lies in the range -MAX_DELTA to +MAX_DELTA, with both ends included (default 32767). A training load outside that range neither allocates an entry nor changes an existing entry.
- R4: If an accepted training load hits an entry whose stored delta equals the new delta, the entry's 2-bit confidence counter goes up by one and saturates at 3.
- R5: If an accepted training load hits an entry whose stored delta differs, the stored delta is replaced and the confidence counter returns to 0.
- R6: A lookup that hits gives predValid = 1 only when the entry's confidence is at least 2. A newly allocated entry starts at confidence 0, so the third matching training load is the first that enables a prediction.
- R7: predValid and predValue reflect the lookup presented in the previous clock cycle. predValid is 0 in any cycle that follows a cycle with lookupValid low.
- R8: A lookup never changes the contents of the table, the confidence counters or the replacement order.
- R9: The set is selected by the low log2(NUM_ENTRIES/NUM_WAYS) bits of the program counter: bits [1:0] at the default of 4 sets of 4 ways. The tag is the full program counter.
- R10: An accepted training load that misses allocates the lowest-numbered invalid way of its set. When the set is full, it replaces the way that was least recently written by training. Every accepted training write makes its way the most recent.
- R11: When a lookup and a training load come in the same cycle, the lookup sees the table as it was before that training write.
- R12: predValue is 0 whenever predValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trainValid | input | 1 | A load is retiring in normal mode this cycle |
| trainPc | input | PC_W | Program counter of the retiring load |
| trainAddr | input | ADDR_W | Effective address of the retiring load |
| trainData | input | ADDR_W | Data value returned by the retiring load |
| lookupValid | input | 1 | A runahead-mode load missed in L2 this cycle |
| lookupPc | input | PC_W | Program counter of the missing load |
| lookupAddr | input | ADDR_W | Effective address of the missing load |
| predValid | output | 1 | Prediction available for the previous cycle's lookup |
| predValue | output | ADDR_W | Predicted loaded value, zero when not valid |

## Verification
The embedded properties assume that the training and lookup inputs are known (not X) on every clock while reset is released. They also assume at most one training load and one lookup per cycle, which is the only thing the ports allow. The assertions also rely on ADDR_W being wider than the stored delta. At the default geometry that means 32-bit addresses and 16-bit deltas.

The stimulus drives every input to a defined value on every cycle, including idle cycles. It keeps the default parameters. It reaches the range bounds, full sets and same-cycle train-and-lookup only through legal port values.

// File: rtl/avd_pkg.sv
package avd_pkg;

  // Strobes issued by the control decision to the table datapath each cycle.
  typedef struct packed {
    logic bumpConf;     // hit with equal delta: raise confidence
    logic newDelta;     // hit with different delta: overwrite, clear confidence
    logic allocate;     // miss: claim a victim way
    logic predCapture;  // lookup qualifies: register a prediction
  } avdStrobes_t;

endpackage

// File: rtl/avd_ctrl.sv
module avd_ctrl
  import avd_pkg::*;
#(
  parameter int CONF_W      = 2,
  parameter int CONF_THRESH = 2
) (
  input  logic              trainValid,
  input  logic              lookupValid,
  input  logic              trainHit,
  input  logic              trainMatch,
  input  logic              trainInRange,
  input  logic              lookupHit,
  input  logic [CONF_W-1:0] lookupConf,
  output avdStrobes_t       strobes
);

  localparam logic [CONF_W-1:0] THRESH = CONF_W'(CONF_THRESH);

  logic trainAccept;

  always_comb begin
    trainAccept         = trainValid && trainInRange;
    strobes.bumpConf    = trainAccept && trainHit && trainMatch;
    strobes.newDelta    = trainAccept && trainHit && !trainMatch;
    strobes.allocate    = trainAccept && !trainHit;
    strobes.predCapture = lookupValid && lookupHit && (lookupConf >= THRESH);
  end

endmodule

// File: rtl/avd_datapath.sv
module avd_datapath
  import avd_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_WAYS    = 4,
  parameter int MAX_DELTA   = 32767,
  parameter int CONF_W      = 2,
  parameter int CONF_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [ADDR_W-1:0] trainAddr,
  input  logic [ADDR_W-1:0] trainData,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  avdStrobes_t       strobes,
  output logic              trainHit,
  output logic              trainMatch,
  output logic              trainInRange,
  output logic              lookupHit,
  output logic [CONF_W-1:0] lookupConf,
  output logic              predValid,
  output logic [ADDR_W-1:0] predValue
);

  localparam int NUM_SETS = NUM_ENTRIES / NUM_WAYS;
  localparam int SET_W    = $clog2(NUM_SETS);
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam int DELTA_W  = $clog2(MAX_DELTA + 1) + 1;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [WAY_W-1:0]  OLDEST   = WAY_W'(NUM_WAYS - 1);
  localparam logic signed [ADDR_W-1:0] LIMIT_HI = ADDR_W'(MAX_DELTA);
  localparam logic signed [ADDR_W-1:0] LIMIT_LO = -LIMIT_HI;

  // Table storage
  logic [NUM_WAYS-1:0] validMem [NUM_SETS];
  logic [PC_W-1:0]     tagMem   [NUM_SETS][NUM_WAYS];
  logic [DELTA_W-1:0]  deltaMem [NUM_SETS][NUM_WAYS];
  logic [CONF_W-1:0]   confMem  [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0]    ageMem   [NUM_SETS][NUM_WAYS];

  logic [SET_W-1:0]          trainSet, lookupSet;
  logic signed [ADDR_W-1:0]  trainDiff;
  logic [DELTA_W-1:0]        trainDelta;
  logic [NUM_WAYS-1:0]       trainHitVec, lookupHitVec;
  logic [WAY_W-1:0]          trainWay, lookupWay, freeWay, oldestWay, victimWay, targetWay;
  logic [DELTA_W-1:0]        lookupDelta;
  logic [ADDR_W-1:0]         lookupPredicted;
  logic                      doWrite;

  assign trainSet     = trainPc[SET_W-1:0];
  assign lookupSet    = lookupPc[SET_W-1:0];
  assign trainDiff    = $signed(trainAddr - trainData);
  assign trainDelta   = trainDiff[DELTA_W-1:0];
  assign trainInRange = (trainDiff <= LIMIT_HI) && (trainDiff >= LIMIT_LO);

  // Per-way tag comparators for both ports
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign trainHitVec[w]  = validMem[trainSet][w]  && (tagMem[trainSet][w]  == trainPc);
    assign lookupHitVec[w] = validMem[lookupSet][w] && (tagMem[lookupSet][w] == lookupPc);
  end

  // Way encoders and victim choice
  always_comb begin
    trainWay  = '0;
    lookupWay = '0;
    freeWay   = '0;
    oldestWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (trainHitVec[w])  trainWay  = WAY_W'(w);
      if (lookupHitVec[w]) lookupWay = WAY_W'(w);
      if (ageMem[trainSet][w] == OLDEST) oldestWay = WAY_W'(w);
    end
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!validMem[trainSet][w]) freeWay = WAY_W'(w);
    end
    victimWay = (&validMem[trainSet]) ? oldestWay : freeWay;
    targetWay = strobes.allocate ? victimWay : trainWay;
  end

  assign trainHit   = |trainHitVec;
  assign trainMatch = deltaMem[trainSet][trainWay] == trainDelta;
  assign lookupHit  = |lookupHitVec;
  assign lookupConf = confMem[lookupSet][lookupWay];
  assign lookupDelta = deltaMem[lookupSet][lookupWay];
  assign lookupPredicted = lookupAddr -
         {{(ADDR_W - DELTA_W){lookupDelta[DELTA_W-1]}}, lookupDelta};
  assign doWrite = strobes.bumpConf || strobes.newDelta || strobes.allocate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validMem[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
          tagMem[s][w]   <= '0;
          deltaMem[s][w] <= '0;
          confMem[s][w]  <= '0;
          ageMem[s][w]   <= WAY_W'(w);
        end
      end
      predValid <= 1'b0;
      predValue <= '0;
    end else begin
      if (strobes.bumpConf && (confMem[trainSet][targetWay] != CONF_MAX))
        confMem[trainSet][targetWay] <= confMem[trainSet][targetWay] + 1'b1;
      if (strobes.newDelta) begin
        deltaMem[trainSet][targetWay] <= trainDelta;
        confMem[trainSet][targetWay]  <= '0;
      end
      if (strobes.allocate) begin
        validMem[trainSet][targetWay] <= 1'b1;
        tagMem[trainSet][targetWay]   <= trainPc;
        deltaMem[trainSet][targetWay] <= trainDelta;
        confMem[trainSet][targetWay]  <= '0;
      end
      if (doWrite) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (WAY_W'(w) == targetWay)
            ageMem[trainSet][w] <= '0;
          else if (ageMem[trainSet][w] < ageMem[trainSet][targetWay])
            ageMem[trainSet][w] <= ageMem[trainSet][w] + 1'b1;
        end
      end
      predValid <= strobes.predCapture;
      predValue <= strobes.predCapture ? lookupPredicted : '0;
    end
  end

  // R3
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.bumpConf || strobes.newDelta || strobes.allocate) |-> trainInRange);

  // R5
  single_write_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.bumpConf, strobes.newDelta, strobes.allocate}));

  // R6
  confident_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.predCapture |-> (lookupHit && (lookupConf >= CONF_W'(CONF_THRESH))));

  // R12
  quiet_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !predValid |-> (predValue == '0));

endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
  import avd_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_WAYS    = 4,
  parameter int MAX_DELTA   = 32767,
  parameter int CONF_W      = 2,
  parameter int CONF_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trainValid,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [ADDR_W-1:0] trainAddr,
  input  logic [ADDR_W-1:0] trainData,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              predValid,
  output logic [ADDR_W-1:0] predValue
);

  avdStrobes_t       strobes;
  logic              trainHit, trainMatch, trainInRange, lookupHit;
  logic [CONF_W-1:0] lookupConf;

  avd_ctrl #(
    .CONF_W      (CONF_W),
    .CONF_THRESH (CONF_THRESH)
  ) u_ctrl (
    .trainValid   (trainValid),
    .lookupValid  (lookupValid),
    .trainHit     (trainHit),
    .trainMatch   (trainMatch),
    .trainInRange (trainInRange),
    .lookupHit    (lookupHit),
    .lookupConf   (lookupConf),
    .strobes      (strobes)
  );

  avd_datapath #(
    .PC_W        (PC_W),
    .ADDR_W      (ADDR_W),
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_WAYS    (NUM_WAYS),
    .MAX_DELTA   (MAX_DELTA),
    .CONF_W      (CONF_W),
    .CONF_THRESH (CONF_THRESH)
  ) u_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .trainPc      (trainPc),
    .trainAddr    (trainAddr),
    .trainData    (trainData),
    .lookupPc     (lookupPc),
    .lookupAddr   (lookupAddr),
    .strobes      (strobes),
    .trainHit     (trainHit),
    .trainMatch   (trainMatch),
    .trainInRange (trainInRange),
    .lookupHit    (lookupHit),
    .lookupConf   (lookupConf),
    .predValid    (predValid),
    .predValue    (predValue)
  );

  // R7
  pred_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    predValid |-> $past(lookupValid));

endmodule

// File: tb/avd_predictor_tb.sv
`timescale 1ns/1ps
module avd_predictor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trainValid = 1'b0;
  logic [31:0] trainPc = '0, trainAddr = '0, trainData = '0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupPc = '0, lookupAddr = '0;
  logic        predValid;
  logic [31:0] predValue;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  avd_predictor u_dut (
    .clk(clk), .rst_n(rst_n),
    .trainValid(trainValid), .trainPc(trainPc), .trainAddr(trainAddr), .trainData(trainData),
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupAddr(lookupAddr),
    .predValid(predValid), .predValue(predValue)
  );

  // Behavioural reference: 4 sets x 4 ways, recency lists per set
  bit          mValid [4][4];
  logic [31:0] mTag   [4][4];
  int          mDelta [4][4];
  int          mConf  [4][4];
  int          mOrder [4][4];   // index 0 = most recent way

  function automatic int findWay(int s, logic [31:0] pc);
    for (int w = 0; w < 4; w++)
      if (mValid[s][w] && mTag[s][w] == pc) return w;
    return -1;
  endfunction

  task automatic touch(int s, int w);
    int p;
    p = 0;
    for (int k = 0; k < 4; k++) if (mOrder[s][k] == w) p = k;
    for (int k = p; k > 0; k--) mOrder[s][k] = mOrder[s][k-1];
    mOrder[s][0] = w;
  endtask

  task automatic modelReset();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        mValid[s][w] = 1'b0; mTag[s][w] = '0; mDelta[s][w] = 0;
        mConf[s][w] = 0; mOrder[s][w] = w;
      end
  endtask

  task automatic modelTrain(logic [31:0] pc, logic [31:0] a, logic [31:0] d);
    int s, w, sd;
    logic [31:0] diff;
    diff = a - d;
    sd = $signed(diff);
    if (sd > 32767 || sd < -32767) return;   // R3 filter
    s = int'(pc[1:0]);
    w = findWay(s, pc);
    if (w >= 0) begin
      if (mDelta[s][w] == sd) begin
        if (mConf[s][w] < 3) mConf[s][w]++;
      end else begin
        mDelta[s][w] = sd; mConf[s][w] = 0;
      end
    end else begin
      w = -1;
      for (int k = 3; k >= 0; k--) if (!mValid[s][k]) w = k;
      if (w < 0) w = mOrder[s][3];
      mValid[s][w] = 1'b1; mTag[s][w] = pc; mDelta[s][w] = sd; mConf[s][w] = 0;
    end
    touch(s, w);
  endtask

  task automatic check(string tag, bit expV, logic [31:0] expVal);
    checkCount++;
    if (predValid !== expV || predValue !== expVal) begin
      failCount++;
      $display("FAIL %s: predValid=%0b predValue=%h expected predValid=%0b predValue=%h",
               tag, predValid, predValue, expV, expVal);
    end
  endtask

  // One clock: drive at negedge, model, wait a full cycle, compare at next negedge
  task automatic step(bit tv, logic [31:0] tpc, logic [31:0] ta, logic [31:0] td,
                      bit lv, logic [31:0] lpc, logic [31:0] la, string tag);
    bit expV;
    logic [31:0] expVal;
    int s, w;
    trainValid = tv; trainPc = tpc; trainAddr = ta; trainData = td;
    lookupValid = lv; lookupPc = lpc; lookupAddr = la;
    expV = 1'b0; expVal = '0;
    s = int'(lpc[1:0]);
    w = findWay(s, lpc);
    if (lv && w >= 0 && mConf[s][w] >= 2) begin
      expV = 1'b1;
      expVal = la - mDelta[s][w];
    end
    if (tv) modelTrain(tpc, ta, td);     // R11: lookup used the pre-train state
    @(posedge clk);
    @(negedge clk);
    check(tag, expV, expVal);
  endtask

  task automatic train(logic [31:0] pc, logic [31:0] a, logic [31:0] d, string tag);
    step(1'b1, pc, a, d, 1'b0, 32'h0, 32'h0, tag);
  endtask

  task automatic look(logic [31:0] pc, logic [31:0] a, string tag);
    step(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, pc, a, tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCount++; failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish();
    end
  end

  logic [31:0] pcs [8];

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    look(32'h0000_1000, 32'h0000_8000, "R1 empty table");
    look(32'h0000_1003, 32'h1234_5678, "R1 empty table");

    // R6 / R2: three matching trainings enable prediction, delta -16
    train(32'h0000_1000, 32'h0000_8000, 32'h0000_8010, "R6");
    look (32'h0000_1000, 32'h0000_9000, "R6 conf0 no pred");
    train(32'h0000_1000, 32'h0000_8100, 32'h0000_8110, "R6");
    look (32'h0000_1000, 32'h0000_9000, "R6 conf1 no pred");
    train(32'h0000_1000, 32'h0000_8200, 32'h0000_8210, "R6");
    look (32'h0000_1000, 32'h0000_9000, "R2 value addr-delta");
    check("R2 explicit", 1'b1, 32'h0000_9010);

    // R4: saturation, then one mismatch clears it
    for (int i = 0; i < 5; i++) train(32'h0000_1000, 32'h0000_A000, 32'h0000_A010, "R4");
    look(32'h0000_1000, 32'hFFFF_FFF8, "R4 saturated, wraps");
    // R5: different delta replaces and clears confidence
    train(32'h0000_1000, 32'h0000_A000, 32'h0000_9FF8, "R5");
    look(32'h0000_1000, 32'h0000_9000, "R5 cleared");
    check("R5 explicit", 1'b0, 32'h0);
    train(32'h0000_1000, 32'h0000_A000, 32'h0000_9FF8, "R5");
    train(32'h0000_1000, 32'h0000_A000, 32'h0000_9FF8, "R5");
    look(32'h0000_1000, 32'h0000_9000, "R5 relearned");
    check("R5 relearned explicit", 1'b1, 32'h0000_8FF8);

    // R3: range bounds
    for (int i = 0; i < 3; i++) train(32'h0000_2001, 32'h0001_0000, 32'h0000_8001, "R3 +max");
    look(32'h0000_2001, 32'h0010_0000, "R3 +max accepted");
    for (int i = 0; i < 3; i++) train(32'h0000_3001, 32'h0000_0001, 32'h0000_8000, "R3 -max");
    look(32'h0000_3001, 32'h0010_0000, "R3 -max accepted");
    for (int i = 0; i < 3; i++) train(32'h0000_4001, 32'h0001_0000, 32'h0000_8000, "R3 over");
    look(32'h0000_4001, 32'h0010_0000, "R3 over ignored");
    train(32'h0000_2001, 32'h0000_0000, 32'h0000_8000, "R3 over on hit");
    look(32'h0000_2001, 32'h0010_0000, "R3 existing untouched");
    check("R3 explicit", 1'b1, 32'h0010_0000 - 32'd32767);

    // R9 / R10: fill set 2, refresh first, allocate fifth
    pcs[0] = 32'h0000_2002; pcs[1] = 32'h0000_3002; pcs[2] = 32'h0000_4002;
    pcs[3] = 32'h0000_5002; pcs[4] = 32'h0000_6002;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 3; i++) train(pcs[p], 32'h100 * (p + 1), 32'h100 * (p + 1) - 32'h40, "R10 fill");
    train(pcs[0], 32'h100, 32'hC0, "R10 refresh");
    for (int i = 0; i < 3; i++) train(pcs[4], 32'h9000, 32'h8FF0, "R10 victim");
    for (int p = 0; p < 5; p++) look(pcs[p], 32'h7777_0000, "R10 after replace");
    look(pcs[1], 32'h7777_0000, "R10 LRU evicted");
    check("R10 explicit evicted", 1'b0, 32'h0);
    look(32'h0000_6003, 32'h7777_0000, "R9 other set miss");

    // R11: same-cycle train and lookup sees old state
    train(32'h0000_7000, 32'h500, 32'h480, "R11");
    train(32'h0000_7000, 32'h500, 32'h480, "R11");
    step(1'b1, 32'h0000_7000, 32'h500, 32'h480, 1'b1, 32'h0000_7000, 32'h2000, "R11 same cycle");
    check("R11 explicit old", 1'b0, 32'h0);
    look(32'h0000_7000, 32'h2000, "R11 next cycle");
    check("R11 explicit new", 1'b1, 32'h1F80);

    // R8: repeated lookups leave state alone; R7: idle after lookup
    for (int i = 0; i < 6; i++) look(32'h0000_7000, 32'h3000 + i, "R8 lookups");
    look(pcs[2], 32'h10, "R8 lru unchanged");
    idle("R7 idle after lookup");
    check("R7 explicit", 1'b0, 32'h0);
    check("R12 value zero", 1'b0, 32'h0);

    // Mixed random traffic against the reference
    for (int i = 0; i < 8; i++) pcs[i] = 32'h0000_1000 * (i + 1) + 32'(i % 4);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, d;
      int pick, kind;
      pick = $urandom_range(7);
      kind = $urandom_range(5);
      a = $urandom;
      case (kind)
        0: d = a - 32'd32767;
        1: d = a + 32'd40000;
        2: d = a + 32'd8;
        default: d = a - 32'd24;
      endcase
      step($urandom_range(1) == 1, pcs[pick], a, d,
           $urandom_range(1) == 1, pcs[$urandom_range(7)], $urandom, "R2 random");
    end

    finish();
  end

endmodule